// File: doc/BRIEF.md
# Access-Rate Refresh Mode Selector

This block chooses between two DRAM refresh policies by how busy the memory is. It counts normal row accesses during each refresh-interval window. The window is marked by a one-cycle tick from the controller's refresh timer, whose period is the full retention interval (for example 64 ms or 32 ms). When a window closes, the block compares the total it saw with two thresholds. Both thresholds are derived from the number of rows: by default a low one at 1 % and a high one at 2 %.

With selective refresh on, the per-row timeout counters run and accessed rows skip their periodic refresh. With it off, the controller falls back to plain counter-addressed auto refresh and the timeout counters are frozen.

The gap between the two thresholds gives hysteresis. A rate that drifts around a single value cannot make the policy flip at every window. The block issues no refresh commands itself.

Top module: `rfsel_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `selective_mode` is 0 (plain auto refresh) and `timeout_run` is 0.
- R2: In plain mode (`selective_mode`=0), a window whose total is greater than HI = floor(ROWS*HI_PCT/100) switches to selective mode. The new value shows on the output in the cycle after the cycle in which `window_tick` is high. The default HI is 163.
- R3: In selective mode (`selective_mode`=1), a window whose total is less than LO = floor(ROWS*LO_PCT/100) switches to plain mode in the cycle after the tick. The default LO is 81.
- R4: A window total in the range LO..HI inclusive leaves the mode unchanged. A total below LO in plain mode also leaves it unchanged, and so does a total above HI in selective mode.
- R5: The mode output changes only in the cycle that follows a `window_tick` cycle.
- R6: The window total counts each cycle in which `row_access` is high, including the cycle of the closing tick itself. After a tick, counting starts again from zero.
- R7: The access count saturates at 2^W-1, where W = clog2(HI+2). With the defaults this is 255, and it never wraps. A window of 300 accesses therefore acts as a total of 255.
- R8: `timeout_run` equals `selective_mode` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| row_access | input | 1 | High for one cycle per normal row activation |
| window_tick | input | 1 | High for one cycle at the end of each refresh-interval window |
| selective_mode | output | 1 | 1 = selective refresh, 0 = plain auto refresh |
| timeout_run | output | 1 | Enable for the per-row timeout counters |

## Verification
Directed windows sit exactly on each threshold and one step beyond it, in both modes. They show whether the comparisons are strict and whether the hysteresis holds. One window places its deciding access on the tick cycle, and a following empty window shows that the count restarted. Windows of 300 accesses tell a saturating counter from a wrapping one, because a wrapped total would land in the opposite band. Seeded random windows with spread-out accesses then exercise the mode tracking over many transitions.

// File: rtl/rfsel_pkg.sv
package rfsel_pkg;

    typedef enum logic {
        POL_PLAIN  = 1'b0,
        POL_SELECT = 1'b1
    } policy_e;

    // Threshold as an integer fraction of the row count, rounded down.
    function automatic int unsigned pct_of(int unsigned rows, int unsigned pct);
        return (rows * pct) / 100;
    endfunction

    // Counter width able to hold one step past the high threshold.
    function automatic int unsigned tally_width(int unsigned hi_th);
        return $clog2(hi_th + 2);
    endfunction

endpackage

// File: rtl/rfsel_tally.sv
module rfsel_tally #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             close,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] win_total
);
    localparam logic [CNT_W-1:0] SAT_V = '1;
    localparam logic [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

    // The total includes an access arriving on the closing cycle.
    always_comb begin
        if (hit && (run_cnt != SAT_V))
            win_total = run_cnt + ONE_V;
        else
            win_total = run_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (close)
            run_cnt <= '0;
        else
            run_cnt <= win_total;
    end
endmodule

// File: rtl/rfsel_decide.sv
module rfsel_decide
    import rfsel_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned LO_TH = 81,
    parameter int unsigned HI_TH = 163
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close,
    input  logic [CNT_W-1:0] win_total,
    output policy_e          state_q,
    output policy_e          state_d
);
    localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO_TH);
    localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI_TH);

    always_comb begin
        state_d = state_q;
        if (close) begin
            case (state_q)
                POL_PLAIN:  if (win_total > HI_V) state_d = POL_SELECT;
                POL_SELECT: if (win_total < LO_V) state_d = POL_PLAIN;
                default:    state_d = POL_PLAIN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= POL_PLAIN;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/rfsel_gate.sv
module rfsel_gate
    import rfsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  policy_e nxt_policy,
    output logic    run
);
    always_ff @(posedge clk) begin
        if (rst)
            run <= 1'b0;
        else
            run <= (nxt_policy == POL_SELECT);
    end
endmodule

// File: rtl/rfsel_top.sv
module rfsel_top
    import rfsel_pkg::*;
#(
    parameter int unsigned ROWS   = 8192,
    parameter int unsigned LO_PCT = 1,
    parameter int unsigned HI_PCT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic row_access,
    input  logic window_tick,
    output logic selective_mode,
    output logic timeout_run
);
    localparam int unsigned LO_TH = pct_of(ROWS, LO_PCT);
    localparam int unsigned HI_TH = pct_of(ROWS, HI_PCT);
    localparam int unsigned CNT_W = tally_width(HI_TH);

    logic [CNT_W-1:0] tally_cnt;
    logic [CNT_W-1:0] tally_total;
    policy_e          pol_q;
    policy_e          pol_d;

    rfsel_tally #(.CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .hit       (row_access),
        .close     (window_tick),
        .run_cnt   (tally_cnt),
        .win_total (tally_total)
    );

    rfsel_decide #(.CNT_W(CNT_W), .LO_TH(LO_TH), .HI_TH(HI_TH)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .close     (window_tick),
        .win_total (tally_total),
        .state_q   (pol_q),
        .state_d   (pol_d)
    );

    rfsel_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .nxt_policy (pol_d),
        .run        (timeout_run)
    );

    assign selective_mode = (pol_q == POL_SELECT);
endmodule

// File: rtl/rfsel_checker.sv
module rfsel_checker #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned LO_TH = 81,
    parameter int unsigned HI_TH = 163
) (
    input logic             clk,
    input logic             rst,
    input logic             row_access,
    input logic             window_tick,
    input logic             selective_mode,
    input logic             timeout_run,
    input logic [CNT_W-1:0] run_cnt,
    input logic [CNT_W-1:0] win_total
);
    localparam logic [CNT_W-1:0] SAT_V = '1;
    localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LO_TH);
    localparam logic [CNT_W-1:0] HI_V  = CNT_W'(HI_TH);

    AST_RESET_PLAIN: assert property (@(posedge clk) rst |=> (!selective_mode && !timeout_run)); // R1
    AST_ENTER_SELECT: assert property (@(posedge clk) disable iff (rst)
        (window_tick && !selective_mode && win_total > HI_V) |=> selective_mode); // R2
    AST_LEAVE_SELECT: assert property (@(posedge clk) disable iff (rst)
        (window_tick && selective_mode && win_total < LO_V) |=> !selective_mode); // R3
    AST_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (window_tick && win_total >= LO_V && win_total <= HI_V) |=> $stable(selective_mode)); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !window_tick |=> $stable(selective_mode)); // R5
    AST_CLEAR_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        window_tick |=> (run_cnt == '0)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == SAT_V && !window_tick) |=> (run_cnt == SAT_V)); // R7
    AST_GATE_MATCH: assert property (@(posedge clk) disable iff (rst)
        timeout_run == selective_mode); // R8
endmodule

bind rfsel_top rfsel_checker #(.CNT_W(CNT_W), .LO_TH(LO_TH), .HI_TH(HI_TH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .row_access     (row_access),
    .window_tick    (window_tick),
    .selective_mode (selective_mode),
    .timeout_run    (timeout_run),
    .run_cnt        (tally_cnt),
    .win_total      (tally_total)
);

// File: tb/rfsel_top_test.sv
module rfsel_top_test;
    localparam int ROWS = 8192;
    localparam int LO   = ROWS * 1 / 100;
    localparam int HI   = ROWS * 2 / 100;
    localparam int W    = $clog2(HI + 2);
    localparam int MAXC = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst, acc, tick;
    logic sel, trun;
    int   checks = 0;
    int   fails  = 0;
    bit   exp_mode = 1'b0;

    always #10 clk = ~clk;

    rfsel_top #(.ROWS(ROWS)) uut (
        .clk            (clk),
        .rst            (rst),
        .row_access     (acc),
        .window_tick    (tick),
        .selective_mode (sel),
        .timeout_run    (trun)
    );

    task automatic check(input logic act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic bit model_next(bit cur, int total);
        if (!cur && total > HI) return 1'b1;
        if (cur && total < LO)  return 1'b0;
        return cur;
    endfunction

    // n accesses, the last one optionally on the tick cycle, random idle gaps.
    task automatic window(input int n, input bit at_tick, input string req);
        int left;
        int total;
        left  = at_tick ? n - 1 : n;
        total = (n > MAXC) ? MAXC : n;
        for (int i = 0; i < left; i++) begin
            @(negedge clk);
            acc = 1'b1;
            for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
                @(negedge clk);
                acc = 1'b0;
            end
        end
        @(negedge clk);
        check(sel, exp_mode, "R5", "mode before tick");
        acc  = at_tick;
        tick = 1'b1;
        @(negedge clk);
        acc  = 1'b0;
        tick = 1'b0;
        exp_mode = model_next(exp_mode, total);
        check(sel, exp_mode, req, $sformatf("mode after window of %0d", n));
        check(trun, exp_mode, "R8", "timeout enable");
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; acc = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        check(sel, 1'b0, "R1", "mode in reset");
        check(trun, 1'b0, "R1", "enable in reset");
        rst = 1'b0;
        @(negedge clk);
        check(sel, 1'b0, "R1", "mode after reset");

        window(0, 1'b0, "R4");        // plain, below LO: stays plain
        window(HI, 1'b0, "R4");       // exactly HI: no switch
        window(HI + 1, 1'b0, "R2");   // one above HI: enable
        window(LO, 1'b0, "R4");       // exactly LO: stays selective
        window(HI, 1'b1, "R4");       // band: stays selective
        window(LO - 1, 1'b0, "R3");   // one below LO: disable
        window(HI + 1, 1'b1, "R6");   // deciding access on tick cycle
        window(0, 1'b0, "R6");        // count restarted: disable
        window(300, 1'b0, "R7");      // saturated, enable (wrap would give 44)
        window(300, 1'b0, "R7");      // saturated, stays selective
        window(LO - 1, 1'b0, "R3");

        for (int k = 0; k < 25; k++) begin
            int n;
            bit t;
            n = int'($urandom_range(0, 250));
            t = (n > 0) ? bit'($urandom_range(0, 1)) : 1'b0;
            window(n, t, "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule